// File: doc/BRIEF.md
# Single-Shot ADC Channel Sequencer

This block is the digital control around an external successive-approximation converter core. Software selects one of eight analog inputs with a channel field and writes an enable bit to request one conversion. The block sends a one-cycle start pulse and the chosen channel index to the core. It then waits for the core to return a done pulse with a 10-bit result.

When the result arrives, it goes into the result register that belongs to the converted channel. In the same cycle a one-cycle completion interrupt is raised, and the enable and busy indications drop back to zero. Each request yields exactly one conversion. Software must write the enable bit again to convert again.

All registers share one address space, and reads are combinational. The control register sits at address 0. Result register n sits at address 8+n.

Top module: `adc_oneshot_seq`

## Requirements
- R1: After reset, every result register reads 0, the control register reads 0, and `irq` and `core_start` are low.
- R2: A write to address 0 with bit 7 set while idle is accepted at that clock edge. In the next cycle `core_start` is high for exactly one cycle, and `core_chan` equals bits [2:0] of that write.
- R3: A `core_done` pulse during a conversion stores `core_data` into result register n, where n is the channel being converted. The other seven result registers keep their values.
- R4: `irq` is high for exactly one cycle. That cycle is the first cycle in which the new result can be read back.
- R5: Control bit 7 (enable) and bit 8 (busy) read 1 from the cycle after acceptance until the result is stored, and 0 afterwards. No further `core_start` occurs without a new enable write.
- R6: An enable write that arrives while a conversion is in progress is ignored. It produces no `core_start` and does not change the target channel.
- R7: Writing a new channel value to the control register during a conversion updates the readable field, bits [2:0], but the current conversion still targets the channel that was latched at acceptance.
- R8: A `core_done` pulse while idle changes no result register and raises no `irq`.
- R9: A read of address 0 returns the channel field in bits [2:0], enable in bit 7 and busy in bit 8, with all other bits 0. A read of address 8+n returns result n zero-extended. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 16 | Read data, combinational |
| core_start | output | 1 | One-cycle conversion request to the core |
| core_chan | output | 3 | Channel index for the core |
| core_done | input | 1 | Core completion pulse |
| core_data | input | 10 | Conversion result from the core |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A latched channel that is wrong, or that drifts, shows up at the port. The `core_chan` output is wrong in the start-pulse cycle itself. One cycle after `core_done`, the result lands in the wrong register, and a sweep that reads all eight registers after every conversion catches this.

A sequencer state that sticks shows up within one cycle of the done pulse. The symptoms are a busy bit that stays high, a missing or repeated `irq`, or a second `core_start` that software never requested.

The sweep covers every channel at several core latencies. It includes enable writes and channel changes made mid-conversion, and done pulses while idle. Each stored value is computed arithmetically from channel and latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Control register bit positions
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned BUSY_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned RES_W = 10,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             wr_en_bit,
  output logic [CH_W-1:0]  chan_field,
  output logic             busy,
  output logic             core_start,
  output logic [CH_W-1:0]  core_chan,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_data,
  output logic [N_CH-1:0]  res_we,
  output logic [RES_W-1:0] res_wdata,
  output logic             irq
);

  seq_state_t      state_q, state_d;
  logic [CH_W-1:0] field_q, field_d;
  logic [CH_W-1:0] act_q, act_d;
  logic            irq_q, irq_d;
  logic            start_req;

  assign start_req = ctrl_we && wr_en_bit;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    field_d = field_q;
    act_d   = act_q;
    irq_d   = 1'b0;
    res_we  = '0;
    if (ctrl_we) field_d = wr_chan;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_START;
          act_d   = wr_chan;
        end
      end
      ST_START: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (core_done) begin
          state_d        = ST_IDLE;
          irq_d          = 1'b1;
          res_we[act_q]  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      field_q <= '0;
      act_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      field_q <= field_d;
      act_q   <= act_d;
      irq_q   <= irq_d;
    end
  end

  assign chan_field = field_q;
  assign busy       = (state_q != ST_IDLE);
  assign core_start = (state_q == ST_START);
  assign core_chan  = act_q;
  assign res_wdata  = core_data;
  assign irq        = irq_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);                                          // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> busy);                                                 // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);                                                        // R4
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);                                                       // R5
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_start) |-> $stable(core_chan));                        // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_we));                                                    // R3
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && core_done) |=> !irq);                                       // R8

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned RES_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CH-1:0]            res_we,
  input  logic [RES_W-1:0]           res_wdata,
  output logic [N_CH-1:0][RES_W-1:0] res_q
);

  for (genvar i = 0; i < N_CH; i++) begin : g_res
    logic [RES_W-1:0] val_d;

    always_comb begin
      val_d = res_q[i];
      if (res_we[i]) val_d = res_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[i] <= '0;
      else        res_q[i] <= val_d;
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !res_we[i] |=> $stable(res_q[i]));                                  // R3
  end

endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic [ADDR_W-1:0]          raddr,
  input  logic [CH_W-1:0]            chan_field,
  input  logic                       busy,
  input  logic [N_CH-1:0][RES_W-1:0] res_q,
  output logic [DATA_W-1:0]          rdata
);

  localparam int unsigned RES_BASE = N_CH;

  always_comb begin
    rdata = '0;
    if (raddr == '0) begin
      rdata[CH_W-1:0] = chan_field;
      rdata[EN_BIT]   = busy;
      rdata[BUSY_BIT] = busy;
    end
    for (int i = 0; i < N_CH; i++) begin
      if (raddr == ADDR_W'(RES_BASE + i)) rdata[RES_W-1:0] = res_q[i];
    end
  end

endmodule

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_waddr,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic [ADDR_W-1:0]             reg_raddr,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          core_start,
  output logic [$clog2(N_CH)-1:0]       core_chan,
  input  logic                          core_done,
  input  logic [RES_W-1:0]              core_data,
  output logic                          irq
);

  localparam int unsigned CH_W = $clog2(N_CH);

  logic                       rst_s_n;
  logic                       ctrl_we;
  logic [CH_W-1:0]            chan_field;
  logic                       busy;
  logic [N_CH-1:0]            res_we;
  logic [RES_W-1:0]           res_wdata;
  logic [N_CH-1:0][RES_W-1:0] res_q;
  logic                       unused_wbits;

  assign ctrl_we      = reg_we && (reg_waddr == '0);
  assign unused_wbits = ^reg_wdata;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  adc_seq_ctrl #(.N_CH(N_CH), .RES_W(RES_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ctrl_we    (ctrl_we),
    .wr_chan    (reg_wdata[CH_W-1:0]),
    .wr_en_bit  (reg_wdata[adc_seq_pkg::EN_BIT]),
    .chan_field (chan_field),
    .busy       (busy),
    .core_start (core_start),
    .core_chan  (core_chan),
    .core_done  (core_done),
    .core_data  (core_data),
    .res_we     (res_we),
    .res_wdata  (res_wdata),
    .irq        (irq)
  );

  adc_result_bank #(.N_CH(N_CH), .RES_W(RES_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .res_we    (res_we),
    .res_wdata (res_wdata),
    .res_q     (res_q)
  );

  adc_read_mux #(.N_CH(N_CH), .RES_W(RES_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .raddr      (reg_raddr),
    .chan_field (chan_field),
    .busy       (busy),
    .res_q      (res_q),
    .rdata      (reg_rdata)
  );

  AST_NO_START_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !core_start) |=> !core_start);                               // R6

endmodule

// File: tb/sim_adc_oneshot_seq.sv
`timescale 1ns/100ps
module sim_adc_oneshot_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic        core_start;
  logic [2:0]  core_chan;
  logic        core_done = 1'b0;
  logic [9:0]  core_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [9:0] model [8];

  always #2.5 clk = ~clk;

  adc_oneshot_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .core_start(core_start), .core_chan(core_chan), .core_done(core_done),
    .core_data(core_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_raddr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic check_bank(input string req);
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), d);
      chk(req, d, {6'd0, model[i]});
    end
  endtask

  // One conversion: channel ch, core latency lat, optional mid-run disturbance
  task automatic convert(input int ch, input int lat, input bit disturb);
    logic [15:0] d;
    logic [9:0]  val;
    int          fld;
    val = 10'((ch * 97 + lat * 13 + 5) & 10'h3FF);
    fld = ch;
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 4'd0; reg_wdata = 16'(ch) | 16'h0080;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R2 start", {15'd0, core_start}, 16'd1);
    chk("R2 chan", {13'd0, core_chan}, 16'(ch));
    rd(4'd0, d);
    chk("R5 busy", d, 16'(ch) | 16'h0180);
    if (disturb) begin
      fld = (ch + 3) % 8;
      reg_we = 1'b1; reg_waddr = 4'd0; reg_wdata = 16'(fld) | 16'h0080;
    end
    @(negedge clk);
    reg_we = 1'b0;
    chk("R2 single", {15'd0, core_start}, 16'd0);
    rd(4'd0, d);
    chk("R7 field", d, 16'(fld) | 16'h0180);
    chk("R7 target", {13'd0, core_chan}, 16'(ch));
    for (int k = 0; k < lat; k++) begin
      chk("R6 no restart", {15'd0, core_start}, 16'd0);
      @(negedge clk);
    end
    core_done = 1'b1; core_data = val;
    @(negedge clk);
    core_done = 1'b0; core_data = '0;
    model[ch] = val;
    chk("R4 irq", {15'd0, irq}, 16'd1);
    check_bank("R3");
    rd(4'd0, d);
    chk("R5 clear", d, 16'(fld));
    @(negedge clk);
    chk("R4 irq pulse", {15'd0, irq}, 16'd0);
    chk("R5 no auto", {15'd0, core_start}, 16'd0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 start", {15'd0, core_start}, 16'd0);
    rd(4'd0, d);
    chk("R1 ctrl", d, 16'd0);
    check_bank("R1");

    // R9 unused addresses
    for (int a = 1; a < 8; a++) begin
      rd(4'(a), d);
      chk("R9 unused", d, 16'd0);
    end

    // Sweep channels and latencies
    for (int lat = 0; lat < 6; lat += 2) begin
      for (int ch = 0; ch < 8; ch++) begin
        convert(ch, lat, ((ch + lat) % 2) == 1);
      end
    end

    // R8 done while idle
    @(negedge clk);
    core_done = 1'b1; core_data = 10'h3FF;
    @(negedge clk);
    core_done = 1'b0; core_data = '0;
    chk("R8 no irq", {15'd0, irq}, 16'd0);
    check_bank("R8");
    @(negedge clk);
    chk("R8 no irq later", {15'd0, irq}, 16'd0);

    // R9 field write without enable
    reg_we = 1'b1; reg_waddr = 4'd0; reg_wdata = 16'h0005;
    @(negedge clk);
    reg_we = 1'b0;
    rd(4'd0, d);
    chk("R9 field only", d, 16'h0005);
    chk("R9 no start", {15'd0, core_start}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule